// File: doc/BRIEF.md
# Block Cipher Memory-to-Memory Sequencer

This block is the control front end of a 128-bit block cipher engine that works from memory to memory. Software sets up a source pointer, a destination pointer, a byte count, a 128-bit key and a 128-bit chaining vector through a 32-bit register port. It then writes a start command. The sequencer fetches each 16-byte block as four 32-bit reads and hands the block to an external cipher core over a valid/ready handshake. It collects the core's result and stores it as four 32-bit writes. The cipher rounds live outside this block, so the core can be any keyed 128-bit permutation.

In chained (CBC) mode, the sequencer does the XOR with the chaining value itself. When a run ends, the chaining value is left in the IV registers, so software can read it back and continue the chain in a later call. Completion sets a sticky pending flag that software clears by writing one to it. A mask bit lets that flag drive an interrupt line.

Top module: `blkc_top`

## Requirements
- R1: After reset every register reads zero, no memory or cipher request is active, and `irq` is low.
- R2: The register port is word addressed (index = byte offset / 4). Control is at index 0x00, status at 0x02, source at 0x04, destination at 0x05, length at 0x06, key words 0..3 at 0x0C..0x0F and IV words 0..3 at 0x10..0x13. Control bits 5:1 read back as written. Control bit 0 reads as busy. Status bits 2:0 are read/write mask bits.
- R3: Writing control with bit 0 set while idle starts a run. A control or IV write made while busy has no effect, including a second start.
- R4: Blocks are handled in ascending address order. Each block is read as four words, lowest address first, and word i becomes bits 32i+31:32i. The result is written back the same way before the next block is read. A memory request stays asserted, with a stable address, until it is acknowledged.
- R5: With control bit 5 clear (ECB), each output block is the cipher core's result for the input block. Control bit 1 set selects encrypt on `cph_encrypt`; clear selects decrypt.
- R6: A start with control bit 2 set copies the key registers (word 0 in bits 31:0) into the key given to the core. A start with bit 2 clear keeps the key loaded by an earlier start, even if the key registers have since been rewritten.
- R7: In CBC encrypt, the core input is the plaintext XOR the chaining value. The output block is the core result, which then becomes the chaining value.
- R8: In CBC decrypt, the output is the core result XOR the chaining value, and the input ciphertext block becomes the chaining value.
- R9: After a CBC run the IV registers hold the last ciphertext block. Splitting a chain over several runs gives the same output as one run.
- R10: Status bit 16 is set when a run completes. Writing 1 to bit 16 clears it, and writing 0 leaves it set. Bit 17 always reads 0.
- R11: A start with a length below 16 bytes sets the pending flag on the second clock edge after the start write, with no memory access.
- R12: `irq` is high exactly while the pending flag and mask bit 0 are both set.
- R13: `cph_in_valid` is held with stable data until `cph_in_ready`. One core transaction is made per block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory access done |
| cph_in_valid | output | 1 | Block offered to cipher core |
| cph_in_ready | input | 1 | Core accepts block |
| cph_in_data | output | 128 | Block to core |
| cph_key | output | 128 | Active key |
| cph_encrypt | output | 1 | Direction to core |
| cph_out_valid | input | 1 | Core result valid |
| cph_out_ready | output | 1 | Sequencer takes result |
| cph_out_data | input | 128 | Core result |
| irq | output | 1 | Masked completion interrupt |

## Verification
The hardest situation to reach is a start command that arrives while a run is in flight. It only matters if it lands in the short window between the first start and completion. The bench reaches that window by issuing the second start right after the first, once it has moved the destination register to a sentinel area. It then confirms that the sentinel is untouched and that no second completion follows. Chain continuation across calls is also indirect. It is reached by splitting one CBC message over two runs without rewriting the IV, and comparing the result with a single run.

// File: rtl/blkc_pkg.sv
package blkc_pkg;
    localparam int unsigned DW    = 32;
    localparam int unsigned BLK   = 128;
    localparam int unsigned WPB   = BLK / DW;
    localparam int unsigned FW    = $clog2(WPB);
    localparam int unsigned WB    = $clog2(DW / 8);
    localparam int unsigned BOFF  = $clog2(BLK / 8);
    localparam int unsigned RA_W  = 5;

    localparam logic [RA_W-1:0] RA_CTRL = 5'h00;
    localparam logic [RA_W-1:0] RA_STAT = 5'h02;
    localparam logic [RA_W-1:0] RA_SRC  = 5'h04;
    localparam logic [RA_W-1:0] RA_DST  = 5'h05;
    localparam logic [RA_W-1:0] RA_LEN  = 5'h06;
    localparam logic [RA_W-1:0] RA_KEY  = 5'h0C;
    localparam logic [RA_W-1:0] RA_IV   = 5'h10;

    localparam int unsigned PEND_BIT = 16;
    localparam int unsigned MASK_W   = 3;

    typedef enum logic [2:0] {
        S_IDLE, S_READ, S_SEND, S_WAIT, S_WRITE, S_FIN
    } seq_state_e;

    // matches control bits 5:1
    typedef struct packed {
        logic chain;
        logic hint_src;
        logic hint_dst;
        logic key_ld;
        logic enc;
    } ctrl_t;

    function automatic logic [BLK-1:0] core_input(input logic [BLK-1:0] blk,
                                                  input logic [BLK-1:0] cv,
                                                  input ctrl_t c);
        return (c.chain && c.enc) ? (blk ^ cv) : blk;
    endfunction

    function automatic logic [BLK-1:0] core_result(input logic [BLK-1:0] res,
                                                   input logic [BLK-1:0] cv,
                                                   input ctrl_t c);
        return (c.chain && !c.enc) ? (res ^ cv) : res;
    endfunction
endpackage

// File: rtl/blkc_chain.sv
module blkc_chain
    import blkc_pkg::*;
(
    input  ctrl_t          cfg,
    input  logic [BLK-1:0] cv,
    input  logic [BLK-1:0] blk_in,
    input  logic [BLK-1:0] core_out,
    output logic [BLK-1:0] core_in,
    output logic [BLK-1:0] result,
    output logic [BLK-1:0] cv_next
);
    always_comb begin
        core_in = core_input(blk_in, cv, cfg);
        result  = core_result(core_out, cv, cfg);
        cv_next = cfg.enc ? core_out : blk_in;
    end
endmodule

// File: rtl/blkc_regfile.sv
module blkc_regfile
    import blkc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            busy,
    input  logic            done,
    input  logic            cv_we,
    input  logic [BLK-1:0]  cv_val,
    output logic            start,
    output ctrl_t           cfg,
    output logic [DW-1:0]   src,
    output logic [DW-1:0]   dst,
    output logic [DW-1:0]   len,
    output logic [BLK-1:0]  key_act,
    output logic [BLK-1:0]  iv,
    output logic            pend,
    output logic            irq
);
    logic [DW-1:0]     key_q [WPB];
    logic [DW-1:0]     iv_q  [WPB];
    logic [BLK-1:0]    key_vec;
    logic [MASK_W-1:0] mask_q;
    logic [FW-1:0]     idx;
    logic              wr_ctrl, in_key, in_iv;

    assign idx     = reg_addr[FW-1:0];
    assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign in_key  = reg_we && (reg_addr[RA_W-1:FW] == RA_KEY[RA_W-1:FW]);
    assign in_iv   = reg_we && (reg_addr[RA_W-1:FW] == RA_IV[RA_W-1:FW]);
    assign start   = wr_ctrl && reg_wdata[0] && !busy;

    for (genvar w = 0; w < WPB; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                key_q[w] <= '0;
            else if (in_key && idx == FW'(w))
                key_q[w] <= reg_wdata;
        end
        always_ff @(posedge clk) begin
            if (rst)
                iv_q[w] <= '0;
            else if (cv_we)
                iv_q[w] <= cv_val[w*DW +: DW];
            else if (in_iv && idx == FW'(w) && !busy)
                iv_q[w] <= reg_wdata;
        end
        assign key_vec[w*DW +: DW] = key_q[w];
        assign iv[w*DW +: DW]      = iv_q[w];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            src     <= '0;
            dst     <= '0;
            len     <= '0;
            key_act <= '0;
            mask_q  <= '0;
            pend    <= 1'b0;
        end else begin
            if (wr_ctrl && !busy)
                cfg <= ctrl_t'(reg_wdata[5:1]);
            if (start && reg_wdata[2])
                key_act <= key_vec;
            if (reg_we && reg_addr == RA_SRC) src <= reg_wdata;
            if (reg_we && reg_addr == RA_DST) dst <= reg_wdata;
            if (reg_we && reg_addr == RA_LEN) len <= reg_wdata;
            if (reg_we && reg_addr == RA_STAT)
                mask_q <= reg_wdata[MASK_W-1:0];
            if (done)
                pend <= 1'b1;
            else if (reg_we && reg_addr == RA_STAT && reg_wdata[PEND_BIT])
                pend <= 1'b0;
        end
    end

    assign irq = pend && mask_q[0];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RA_CTRL)
            reg_rdata = {{(DW-6){1'b0}}, cfg, busy};
        else if (reg_addr == RA_STAT) begin
            reg_rdata[MASK_W-1:0] = mask_q;
            reg_rdata[PEND_BIT]   = pend;
        end
        else if (reg_addr == RA_SRC) reg_rdata = src;
        else if (reg_addr == RA_DST) reg_rdata = dst;
        else if (reg_addr == RA_LEN) reg_rdata = len;
        else if (reg_addr[RA_W-1:FW] == RA_KEY[RA_W-1:FW]) reg_rdata = key_q[idx];
        else if (reg_addr[RA_W-1:FW] == RA_IV[RA_W-1:FW])  reg_rdata = iv_q[idx];
    end
endmodule

// File: rtl/blkc_seq.sv
module blkc_seq
    import blkc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [DW-1:0]        src,
    input  logic [DW-1:0]        dst,
    input  logic [DW-1:0]        len,
    output logic                 busy,
    output logic                 done,
    output logic                 take,
    output logic [BLK-1:0]       blk,
    input  logic [BLK-1:0]       result,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [DW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_ack,
    output logic                 cph_in_valid,
    input  logic                 cph_in_ready,
    input  logic                 cph_out_valid,
    output logic                 cph_out_ready
);
    localparam int unsigned CW = DW - BOFF;

    seq_state_e                 state;
    logic [DW-1:0]              rd_a, wr_a;
    logic [CW-1:0]              left;
    logic [FW-1:0]              widx;
    logic [WPB-1:0][DW-1:0]     blk_q;
    logic                       last_word;

    assign last_word = (widx == FW'(WPB - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            rd_a  <= '0;
            wr_a  <= '0;
            left  <= '0;
            widx  <= '0;
            blk_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    rd_a  <= src;
                    wr_a  <= dst;
                    left  <= len[DW-1:BOFF];
                    widx  <= '0;
                    state <= (len[DW-1:BOFF] == '0) ? S_FIN : S_READ;
                end
                S_READ: if (mem_ack) begin
                    blk_q[widx] <= mem_rdata;
                    widx        <= widx + 1'b1;
                    if (last_word) state <= S_SEND;
                end
                S_SEND: if (cph_in_ready) state <= S_WAIT;
                S_WAIT: if (cph_out_valid) begin
                    blk_q <= result;
                    state <= S_WRITE;
                end
                S_WRITE: if (mem_ack) begin
                    widx <= widx + 1'b1;
                    if (last_word) begin
                        rd_a  <= rd_a + DW'(BLK / 8);
                        wr_a  <= wr_a + DW'(BLK / 8);
                        left  <= left - 1'b1;
                        state <= (left == CW'(1)) ? S_FIN : S_READ;
                    end
                end
                S_FIN: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy          = (state != S_IDLE);
        done          = (state == S_FIN);
        mem_req       = (state == S_READ) || (state == S_WRITE);
        mem_we        = (state == S_WRITE);
        mem_addr      = ((state == S_WRITE) ? wr_a : rd_a) + DW'({widx, WB'(0)});
        mem_wdata     = blk_q[widx];
        cph_in_valid  = (state == S_SEND);
        cph_out_ready = (state == S_WAIT);
        take          = (state == S_WAIT) && cph_out_valid;
        blk           = blk_q;
    end
endmodule

// File: rtl/blkc_top.sv
module blkc_top
    import blkc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [4:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ack,
    output logic            cph_in_valid,
    input  logic            cph_in_ready,
    output logic [127:0]    cph_in_data,
    output logic [127:0]    cph_key,
    output logic            cph_encrypt,
    input  logic            cph_out_valid,
    output logic            cph_out_ready,
    input  logic [127:0]    cph_out_data,
    output logic            irq
);
    ctrl_t          cfg;
    logic           start, seq_busy, seq_done, take, pend_a, cv_we;
    logic [DW-1:0]  src, dst, len;
    logic [BLK-1:0] iv, blk, result, cv_next;

    assign cv_we       = take && cfg.chain;
    assign cph_encrypt = cfg.enc;

    blkc_regfile u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(seq_busy), .done(seq_done), .cv_we(cv_we), .cv_val(cv_next),
        .start(start), .cfg(cfg), .src(src), .dst(dst), .len(len),
        .key_act(cph_key), .iv(iv), .pend(pend_a), .irq(irq)
    );

    blkc_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .src(src), .dst(dst), .len(len),
        .busy(seq_busy), .done(seq_done), .take(take), .blk(blk), .result(result),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .cph_in_valid(cph_in_valid), .cph_in_ready(cph_in_ready),
        .cph_out_valid(cph_out_valid), .cph_out_ready(cph_out_ready)
    );

    blkc_chain u_chain (
        .cfg(cfg), .cv(iv), .blk_in(blk), .core_out(cph_out_data),
        .core_in(cph_in_data), .result(result), .cv_next(cv_next)
    );
endmodule

// File: rtl/blkc_chk.sv
module blkc_chk (
    input logic         clk,
    input logic         rst,
    input logic         mem_req,
    input logic         mem_ack,
    input logic         mem_we,
    input logic [31:0]  mem_addr,
    input logic         cph_in_valid,
    input logic         cph_in_ready,
    input logic [127:0] cph_in_data,
    input logic         cph_out_ready,
    input logic         pend,
    input logic         done
);
    // R4
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R13
    cph_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cph_in_valid && !cph_in_ready) |=> (cph_in_valid && $stable(cph_in_data)));

    // R4
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_req, cph_in_valid, cph_out_ready}));

    // R10
    pend_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(done));
endmodule

bind blkc_top blkc_chk u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .cph_in_valid(cph_in_valid),
    .cph_in_ready(cph_in_ready), .cph_in_data(cph_in_data),
    .cph_out_ready(cph_out_ready), .pend(pend_a), .done(seq_done)
);

// File: tb/test_blkc_top.sv
module test_blkc_top;
    logic         clk = 0;
    logic         rst = 1;
    logic         reg_we = 0;
    logic [4:0]   reg_addr = 0;
    logic [31:0]  reg_wdata = 0;
    logic [31:0]  reg_rdata;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr, mem_wdata;
    logic [31:0]  mem_rdata = 0;
    logic         mem_ack = 0;
    logic         cph_in_valid, cph_in_ready, cph_encrypt, cph_out_valid, cph_out_ready;
    logic [127:0] cph_in_data, cph_key, cph_out_data;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    int accesses = 0;
    int core_tx = 0;

    logic [31:0]  mem [256];
    logic         cbusy = 0;
    logic [127:0] cres = 0;

    always #10 clk = ~clk;

    blkc_top i_blkc_top (.*);

    function automatic logic [127:0] enc_f(input logic [127:0] x, input logic [127:0] k);
        logic [127:0] t;
        t = x ^ k;
        return {t[119:0], t[127:120]};
    endfunction

    function automatic logic [127:0] dec_f(input logic [127:0] y, input logic [127:0] k);
        return {y[7:0], y[127:8]} ^ k;
    endfunction

    // memory model: ack one cycle after request
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack  <= 1'b1;
            accesses <= accesses + 1;
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end else
            mem_ack <= 1'b0;
    end

    // cipher stub with one cycle of latency
    assign cph_in_ready  = !cbusy;
    assign cph_out_valid = cbusy;
    assign cph_out_data  = cres;
    always @(posedge clk) begin
        if (rst) cbusy <= 1'b0;
        else if (!cbusy && cph_in_valid) begin
            cbusy   <= 1'b1;
            core_tx <= core_tx + 1;
            cres    <= cph_encrypt ? enc_f(cph_in_data, cph_key) : dec_f(cph_in_data, cph_key);
        end else if (cbusy && cph_out_ready)
            cbusy <= 1'b0;
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_blk(input int addr, input logic [127:0] v);
        for (int w = 0; w < 4; w++) mem[(addr >> 2) + w] = v[w*32 +: 32];
    endtask

    function automatic logic [127:0] get_blk(input int addr);
        return {mem[(addr>>2)+3], mem[(addr>>2)+2], mem[(addr>>2)+1], mem[addr>>2]};
    endfunction

    task automatic set128(input logic [4:0] base, input logic [127:0] v);
        for (int w = 0; w < 4; w++) wr(base + 5'(w), v[w*32 +: 32]);
    endtask

    task automatic get128(input logic [4:0] base, output logic [127:0] v);
        logic [31:0] d;
        for (int w = 0; w < 4; w++) begin
            rd(base + 5'(w), d);
            v[w*32 +: 32] = d;
        end
    endtask

    task automatic wait_pend();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(5'h02, s);
            if (s[16]) return;
        end
        chk("R10 completion timeout", 0, 1);
    endtask

    task automatic run(input int s, input int d, input int len, input logic [31:0] c);
        wr(5'h04, s); wr(5'h05, d); wr(5'h06, len);
        wr(5'h00, c | 32'h1);
        wait_pend();
        wr(5'h02, 32'h0001_0000 | 32'h1);
    endtask

    // expected model for a whole run
    task automatic model(input int nb, input logic [127:0] k, input bit e, input bit cbc,
                         input logic [127:0] p [3], inout logic [127:0] cv,
                         output logic [127:0] q [3]);
        logic [127:0] y;
        for (int i = 0; i < nb; i++) begin
            if (e) begin
                y = enc_f(cbc ? (p[i] ^ cv) : p[i], k);
                if (cbc) cv = y;
            end else begin
                y = dec_f(p[i], k);
                if (cbc) begin y = y ^ cv; cv = p[i]; end
            end
            q[i] = y;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0]  d;
        logic [127:0] v, k1, k2, ivx, cv;
        logic [127:0] pt [3];
        logic [127:0] ct [3];
        logic [127:0] ex [3];
        int a0;
        void'($urandom(32'h5EED_0017));
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(5'h00, d); chk("R1 ctrl", d, 0);
        rd(5'h02, d); chk("R1 status", d, 0);
        rd(5'h12, d); chk("R1 iv word", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 mem_req", mem_req, 0);

        // R2 map and readback
        wr(5'h04, 32'h0000_0120); rd(5'h04, d); chk("R2 src", d, 32'h120);
        wr(5'h06, 32'h0000_0030); rd(5'h06, d); chk("R2 len", d, 32'h30);
        wr(5'h02, 32'h7); rd(5'h02, d); chk("R2 mask", d, 32'h7);
        wr(5'h00, 32'h18); rd(5'h00, d); chk("R2 hint bits", d, 32'h18);
        wr(5'h0D, 32'hCAFE_0001); rd(5'h0D, d); chk("R2 key word1", d, 32'hCAFE_0001);

        // R5 ECB encrypt two blocks with key load
        k1 = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
        set128(5'h0C, k1);
        pt[0] = 128'h00112233_44556677_8899aabb_ccddeeff;
        pt[1] = 128'h01020304_05060708_090a0b0c_0d0e0f10;
        put_blk(32'h000, pt[0]); put_blk(32'h010, pt[1]);
        a0 = core_tx;
        wr(5'h04, 32'h000); wr(5'h05, 32'h200); wr(5'h06, 32);
        wr(5'h00, 32'h07);
        wait_pend();
        chk("R5 ecb blk0", get_blk(32'h200), enc_f(pt[0], k1));
        chk("R4 ecb blk1 order", get_blk(32'h210), enc_f(pt[1], k1));
        chk("R4 word0 low addr", mem[32'h200 >> 2], enc_f(pt[0], k1) & 128'hffffffff);
        chk("R13 one core tx per block", core_tx - a0, 2);
        rd(5'h02, d); chk("R10 pending set", d[17:16], 2'b01);
        chk("R12 irq on", irq, 1);
        wr(5'h02, 32'h1); rd(5'h02, d); chk("R10 write0 keeps", d[16], 1);
        wr(5'h02, 32'h0001_0001); rd(5'h02, d); chk("R10 w1c", d[16], 0);
        chk("R12 irq off", irq, 0);
        wr(5'h02, 32'h0);

        // R6 key kept when bit 2 clear
        k2 = 128'hdeadbeef_01234567_89abcdef_55aa55aa;
        set128(5'h0C, k2);
        run(32'h200, 32'h100, 32, 32'h00);
        chk("R6 retained key blk0", get_blk(32'h100), pt[0]);
        chk("R6 retained key blk1", get_blk(32'h110), pt[1]);

        // R7 CBC encrypt, R9 IV writeback
        ivx = 128'h11111111_22222222_33333333_44444444;
        pt[2] = 128'hfedcba98_76543210_0f0f0f0f_f0f0f0f0;
        for (int i = 0; i < 3; i++) put_blk(32'h000 + 16*i, pt[i]);
        set128(5'h10, ivx);
        cv = ivx;
        model(3, k2, 1, 1, pt, cv, ex);
        run(32'h000, 32'h200, 48, 32'h26);
        for (int i = 0; i < 3; i++) begin
            ct[i] = get_blk(32'h200 + 16*i);
            chk("R7 cbc enc", ct[i], ex[i]);
        end
        get128(5'h10, v); chk("R9 iv after enc", v, ex[2]);

        // R8 CBC decrypt, R9 IV = last ciphertext
        set128(5'h10, ivx);
        run(32'h200, 32'h300, 48, 32'h24);
        for (int i = 0; i < 3; i++) chk("R8 cbc dec", get_blk(32'h300 + 16*i), pt[i]);
        get128(5'h10, v); chk("R9 iv after dec", v, ct[2]);

        // R9 chain continued across two runs
        set128(5'h10, ivx);
        run(32'h000, 32'h100, 32, 32'h26);
        run(32'h020, 32'h120, 16, 32'h26);
        for (int i = 0; i < 3; i++) chk("R9 split chain", get_blk(32'h100 + 16*i), ct[i]);

        // R11 zero length
        a0 = accesses;
        wr(5'h06, 0); wr(5'h02, 32'h0);
        @(negedge clk);
        reg_we = 1; reg_addr = 5'h00; reg_wdata = 32'h03;
        @(negedge clk);
        reg_we = 0; reg_addr = 5'h02;
        #1 chk("R11 not yet pending", reg_rdata[16], 0);
        @(negedge clk);
        #1 chk("R11 pending after one cycle", reg_rdata[16], 1);
        chk("R11 no memory traffic", accesses - a0, 0);
        wr(5'h02, 32'h0001_0000);

        // R3 start while busy is ignored
        for (int w = 0; w < 4; w++) mem[(32'h380 >> 2) + w] = 32'hA5A5_0000 + w;
        wr(5'h04, 32'h000); wr(5'h05, 32'h340); wr(5'h06, 16);
        wr(5'h00, 32'h07);
        wr(5'h05, 32'h380);
        wr(5'h00, 32'h01);
        rd(5'h00, d); chk("R3 busy cfg kept", d[5:1], 5'b00011);
        wait_pend();
        wr(5'h02, 32'h0001_0000);
        chk("R3 first run done", get_blk(32'h340), enc_f(pt[0], k2));
        chk("R3 sentinel untouched", get_blk(32'h380),
            {32'hA5A5_0003, 32'hA5A5_0002, 32'hA5A5_0001, 32'hA5A5_0000});
        repeat (60) @(negedge clk);
        rd(5'h02, d); chk("R3 no second completion", d[16], 0);

        // random mix of modes
        for (int it = 0; it < 8; it++) begin
            int nb;
            bit e, cbc;
            logic [127:0] k, iv0;
            nb  = 1 + int'($urandom % 3);
            e   = 1'($urandom % 2);
            cbc = 1'($urandom % 2);
            k   = {$urandom, $urandom, $urandom, $urandom};
            iv0 = {$urandom, $urandom, $urandom, $urandom};
            for (int i = 0; i < 3; i++) begin
                pt[i] = {$urandom, $urandom, $urandom, $urandom};
                put_blk(32'h000 + 16*i, pt[i]);
            end
            set128(5'h0C, k);
            set128(5'h10, iv0);
            cv = iv0;
            model(nb, k, e, cbc, pt, cv, ex);
            run(32'h000, 32'h200, nb*16, {26'b0, cbc, 2'b00, 1'b1, e, 1'b0});
            for (int i = 0; i < nb; i++)
                chk(cbc ? (e ? "R7 random" : "R8 random") : "R5 random",
                    get_blk(32'h200 + 16*i), ex[i]);
            get128(5'h10, v);
            chk("R9 random iv", v, cv);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule